// File: doc/BRIEF.md
# Write-Leveling Delay Finalizer

This block sits at the end of a DDR write-leveling sweep. For every byte lane, the sweep reports the largest region of delay settings in which the strobe was seen to pass. The block turns each region into the two transmit delay codes the data path uses: one for the strobe (DQS) and one for the data bits (DQ). It also checks that each region is credible before it uses the result.

A pulse on `start_i` captures all region starts and widths, the x16 flag and the correction flag. The block then visits the lanes in ascending order, one lane per clock cycle.

For each lane it does the following:
- It checks that the region width lies strictly inside a plausible window for a phase measurement.
- On x16 devices it folds an odd lane's start by one whole cycle of 128 codes, so that the start lies within half a cycle of its even partner.
- If correction is enabled, it adds one qclk (64 codes).
- It places DQ 32 codes after DQS.

The first lane that fails a check stops the pass. The block then reports which lane failed and why. All codes are 10-bit unsigned values.

Top module: `wlf_finalizer`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `err_o` are 0, `err_cause_o` is 0, and every DQS and DQ code is 0.
- R2: A start accepted while idle clears all codes and the error outputs. The block then writes one lane per cycle in ascending order. Lane i occupies bits [i*10 +: 10] of each code bus. Without an error, `busy_o` is high for exactly NUM_LANES cycles. `done_o` is high for one cycle only, in the cycle that follows the last busy cycle.
- R3: A lane whose region width is 32 or less is rejected with cause 1. The outputs are `err_o`=1 and `err_lane_o`=lane. That lane and all later lanes keep zero codes, and earlier lanes keep their results. `done_o` comes in the cycle after the failing lane was visited.
- R4: A lane whose region width is 96 or more is rejected with cause 2, and processing stops as in R3.
- R5: Widths of 33 and 95 are accepted.
- R6: With x16 set, an odd lane's start that exceeds its even partner's raw start by more than 64 is reduced by 128.
- R7: With x16 set, an odd lane's start that is more than 64 below the partner's start is increased by 128. A difference of exactly ±64 leaves the start unchanged. Even lanes are never folded, and with x16 clear no lane is folded.
- R8: With the correction flag set, 64 is added to every DQS code, after folding.
- R9: Every written DQ code equals its DQS code plus 32.
- R10: If the final DQS value would be negative, or the DQ value would exceed 1023, the lane is rejected with cause 3 and processing stops as in R3.
- R11: A start pulse that arrives while busy is ignored. It has no effect on results or timing.
- R12: The inputs are used only as captured at the accepted start. Changes during a pass have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a pass (accepted only while idle) |
| region_start_i | input | NUM_LANES*CODE_W | Per-lane region start, lane i at [i*CODE_W +: CODE_W] |
| region_width_i | input | NUM_LANES*CODE_W | Per-lane region width |
| x16_i | input | 1 | Device is x16: fold odd lanes to their partner |
| qclk_fix_i | input | 1 | Add one qclk to every DQS code |
| dqs_code_o | output | NUM_LANES*CODE_W | Final DQS delay codes |
| dq_code_o | output | NUM_LANES*CODE_W | Final DQ delay codes |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle pulse at the end of a pass |
| err_o | output | 1 | Last pass stopped on a failing lane |
| err_lane_o | output | $clog2(NUM_LANES) | Index of the failing lane |
| err_cause_o | output | 2 | 0 none, 1 too narrow, 2 too wide, 3 out of range |

## Verification
Take the clock edge that samples the start as edge 0. Lane i is written at edge i+1, and `busy_o` becomes visible one sample later. A clean pass raises `done_o` after edge NUM_LANES. A failure at lane j raises `done_o`, `err_o`, the lane index and the cause together after edge j+1. The bench drives and samples on falling edges. It counts falling edges from the release of start and requires `done_o` at exactly the computed sample, with `busy_o` high on every sample before it. Codes and error fields are compared only once `done_o` is seen. One sample later it confirms that `done_o` has dropped.

// File: rtl/wlf_pkg.sv
package wlf_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_NARROW = 2'd1,
    CAUSE_WIDE   = 2'd2,
    CAUSE_RANGE  = 2'd3
  } wlf_cause_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } wlf_state_e;

endpackage

// File: rtl/wlf_capture.sv
module wlf_capture #(
  parameter int NUM_LANES = 8,
  parameter int CODE_W    = 10,
  localparam int BUS_W    = NUM_LANES * CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [BUS_W-1:0] start_flat_i,
  input  logic [BUS_W-1:0] width_flat_i,
  input  logic             x16_i,
  input  logic             fix_i,
  output logic [BUS_W-1:0] start_flat_o,
  output logic [BUS_W-1:0] width_flat_o,
  output logic             x16_o,
  output logic             fix_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_flat_o <= '0;
      width_flat_o <= '0;
      x16_o        <= 1'b0;
      fix_o        <= 1'b0;
    end else if (load_i) begin
      start_flat_o <= start_flat_i;
      width_flat_o <= width_flat_i;
      x16_o        <= x16_i;
      fix_o        <= fix_i;
    end
  end

endmodule

// File: rtl/wlf_lane_calc.sv
module wlf_lane_calc
  import wlf_pkg::*;
#(
  parameter int NUM_LANES   = 8,
  parameter int CODE_W      = 10,
  parameter int WIDTH_MIN   = 32,
  parameter int WIDTH_MAX   = 96,
  parameter int CYCLE_CODES = 128,
  parameter int QCLK_CODES  = 64,
  parameter int DQ_LAG      = 32,
  localparam int BUS_W      = NUM_LANES * CODE_W,
  localparam int LANE_W     = $clog2(NUM_LANES)
) (
  input  logic [LANE_W-1:0] lane_i,
  input  logic [BUS_W-1:0]  start_flat_i,
  input  logic [BUS_W-1:0]  width_flat_i,
  input  logic              x16_i,
  input  logic              fix_i,
  output logic [CODE_W-1:0] dqs_o,
  output logic [CODE_W-1:0] dq_o,
  output wlf_cause_e        cause_o
);

  localparam int CW = CODE_W + 2;
  localparam logic signed [CW-1:0] CYCLE_S = CW'(CYCLE_CODES);
  localparam logic signed [CW-1:0] HALF_S  = CW'(CYCLE_CODES / 2);
  localparam logic signed [CW-1:0] QCLK_S  = CW'(QCLK_CODES);
  localparam logic signed [CW-1:0] LAG_S   = CW'(DQ_LAG);
  localparam logic signed [CW-1:0] MAXC_S  = CW'((1 << CODE_W) - 1);
  localparam logic [CODE_W-1:0]    WMIN_C  = CODE_W'(WIDTH_MIN);
  localparam logic [CODE_W-1:0]    WMAX_C  = CODE_W'(WIDTH_MAX);

  function automatic wlf_cause_e width_verdict(input logic [CODE_W-1:0] w);
    if (w <= WMIN_C)      return CAUSE_NARROW;
    else if (w >= WMAX_C) return CAUSE_WIDE;
    else                  return CAUSE_NONE;
  endfunction

  function automatic logic signed [CW-1:0] fold_to_partner(
    input logic signed [CW-1:0] own,
    input logic signed [CW-1:0] partner
  );
    if (own > partner + HALF_S)      return own - CYCLE_S;
    else if (own < partner - HALF_S) return own + CYCLE_S;
    else                             return own;
  endfunction

  function automatic logic out_of_range(input logic signed [CW-1:0] dqs);
    return (dqs < 0) || (dqs + LAG_S > MAXC_S);
  endfunction

  logic [LANE_W-1:0]        partner_lane;
  logic [CODE_W-1:0]        own_start, partner_start, own_width;
  logic signed [CW-1:0]     folded_s, dqs_s;
  wlf_cause_e               width_cause;
  logic                     fold_en;

  assign partner_lane = lane_i & ~LANE_W'(1);
  assign fold_en      = x16_i & lane_i[0];

  always_comb begin
    own_start     = start_flat_i[int'(lane_i) * CODE_W +: CODE_W];
    own_width     = width_flat_i[int'(lane_i) * CODE_W +: CODE_W];
    partner_start = start_flat_i[int'(partner_lane) * CODE_W +: CODE_W];
  end

  always_comb begin
    folded_s = fold_en ? fold_to_partner(CW'(own_start), CW'(partner_start))
                       : CW'(own_start);
    dqs_s    = fix_i ? folded_s + QCLK_S : folded_s;
  end

  assign width_cause = width_verdict(own_width);

  always_comb begin
    if (width_cause != CAUSE_NONE) cause_o = width_cause;
    else if (out_of_range(dqs_s))  cause_o = CAUSE_RANGE;
    else                           cause_o = CAUSE_NONE;
  end

  assign dqs_o = dqs_s[CODE_W-1:0];
  assign dq_o  = dqs_o + CODE_W'(DQ_LAG);

endmodule

// File: rtl/wlf_seq.sv
module wlf_seq
  import wlf_pkg::*;
#(
  parameter int NUM_LANES = 8,
  localparam int LANE_W   = $clog2(NUM_LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  wlf_cause_e        cause_i,
  output logic              load_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              wr_o,
  output logic              fail_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [LANE_W-1:0] err_lane_o,
  output wlf_cause_e        err_cause_o
);

  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);

  wlf_state_e state_q;
  logic       last_w;

  assign busy_o = (state_q == ST_RUN);
  assign load_o = (state_q == ST_IDLE) && start_i;
  assign fail_o = busy_o && (cause_i != CAUSE_NONE);
  assign wr_o   = busy_o && (cause_i == CAUSE_NONE);
  assign last_w = (lane_o == LAST_LANE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      lane_o      <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      err_lane_o  <= '0;
      err_cause_o <= CAUSE_NONE;
    end else begin
      done_o <= 1'b0;
      if (load_o) begin
        state_q     <= ST_RUN;
        lane_o      <= '0;
        err_o       <= 1'b0;
        err_lane_o  <= '0;
        err_cause_o <= CAUSE_NONE;
      end else if (fail_o) begin
        state_q     <= ST_IDLE;
        done_o      <= 1'b1;
        err_o       <= 1'b1;
        err_lane_o  <= lane_o;
        err_cause_o <= cause_i;
      end else if (wr_o) begin
        if (last_w) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
        end else begin
          lane_o <= lane_o + LANE_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/wlf_code_store.sv
module wlf_code_store #(
  parameter int NUM_LANES = 8,
  parameter int CODE_W    = 10,
  localparam int BUS_W    = NUM_LANES * CODE_W,
  localparam int LANE_W   = $clog2(NUM_LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              wr_i,
  input  logic [LANE_W-1:0] wr_lane_i,
  input  logic [CODE_W-1:0] dqs_i,
  input  logic [CODE_W-1:0] dq_i,
  output logic [BUS_W-1:0]  dqs_flat_o,
  output logic [BUS_W-1:0]  dq_flat_o
);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic hit;
    assign hit = wr_i && (wr_lane_i == LANE_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dqs_flat_o[g*CODE_W +: CODE_W] <= '0;
        dq_flat_o[g*CODE_W +: CODE_W]  <= '0;
      end else if (clear_i) begin
        dqs_flat_o[g*CODE_W +: CODE_W] <= '0;
        dq_flat_o[g*CODE_W +: CODE_W]  <= '0;
      end else if (hit) begin
        dqs_flat_o[g*CODE_W +: CODE_W] <= dqs_i;
        dq_flat_o[g*CODE_W +: CODE_W]  <= dq_i;
      end
    end
  end

endmodule

// File: rtl/wlf_finalizer.sv
module wlf_finalizer
  import wlf_pkg::*;
#(
  parameter int NUM_LANES   = 8,
  parameter int CODE_W      = 10,
  parameter int WIDTH_MIN   = 32,
  parameter int WIDTH_MAX   = 96,
  parameter int CYCLE_CODES = 128,
  parameter int QCLK_CODES  = 64,
  parameter int DQ_LAG      = 32,
  localparam int BUS_W      = NUM_LANES * CODE_W,
  localparam int LANE_W     = $clog2(NUM_LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BUS_W-1:0]  region_start_i,
  input  logic [BUS_W-1:0]  region_width_i,
  input  logic              x16_i,
  input  logic              qclk_fix_i,
  output logic [BUS_W-1:0]  dqs_code_o,
  output logic [BUS_W-1:0]  dq_code_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [LANE_W-1:0] err_lane_o,
  output logic [1:0]        err_cause_o
);

  logic [BUS_W-1:0]  cap_start, cap_width;
  logic              cap_x16, cap_fix;
  logic              accept_w, lane_wr_w, lane_fail_w;
  logic [LANE_W-1:0] cur_lane_w;
  logic [CODE_W-1:0] lane_dqs_w, lane_dq_w;
  wlf_cause_e        lane_cause_w, err_cause_w;

  wlf_capture #(.NUM_LANES(NUM_LANES), .CODE_W(CODE_W)) u_capture (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (accept_w),
    .start_flat_i (region_start_i),
    .width_flat_i (region_width_i),
    .x16_i        (x16_i),
    .fix_i        (qclk_fix_i),
    .start_flat_o (cap_start),
    .width_flat_o (cap_width),
    .x16_o        (cap_x16),
    .fix_o        (cap_fix)
  );

  wlf_lane_calc #(
    .NUM_LANES  (NUM_LANES),
    .CODE_W     (CODE_W),
    .WIDTH_MIN  (WIDTH_MIN),
    .WIDTH_MAX  (WIDTH_MAX),
    .CYCLE_CODES(CYCLE_CODES),
    .QCLK_CODES (QCLK_CODES),
    .DQ_LAG     (DQ_LAG)
  ) u_calc (
    .lane_i       (cur_lane_w),
    .start_flat_i (cap_start),
    .width_flat_i (cap_width),
    .x16_i        (cap_x16),
    .fix_i        (cap_fix),
    .dqs_o        (lane_dqs_w),
    .dq_o         (lane_dq_w),
    .cause_o      (lane_cause_w)
  );

  wlf_seq #(.NUM_LANES(NUM_LANES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cause_i     (lane_cause_w),
    .load_o      (accept_w),
    .lane_o      (cur_lane_w),
    .wr_o        (lane_wr_w),
    .fail_o      (lane_fail_w),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .err_lane_o  (err_lane_o),
    .err_cause_o (err_cause_w)
  );

  wlf_code_store #(.NUM_LANES(NUM_LANES), .CODE_W(CODE_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (accept_w),
    .wr_i       (lane_wr_w),
    .wr_lane_i  (cur_lane_w),
    .dqs_i      (lane_dqs_w),
    .dq_i       (lane_dq_w),
    .dqs_flat_o (dqs_code_o),
    .dq_flat_o  (dq_code_o)
  );

  assign err_cause_o = err_cause_w;

endmodule

// File: rtl/wlf_finalizer_chk.sv
module wlf_finalizer_chk #(
  parameter int NUM_LANES = 8,
  parameter int CODE_W    = 10,
  parameter int DQ_LAG    = 32,
  localparam int BUS_W    = NUM_LANES * CODE_W,
  localparam int CNT_W    = $clog2(NUM_LANES) + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic [1:0]       err_cause_o,
  input logic             lane_fail_w,
  input logic [BUS_W-1:0] dqs_code_o,
  input logic [BUS_W-1:0] dq_code_o
);

  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + CNT_W'(1);
    else             run_cnt <= '0;
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_busy_done_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_cnt < CNT_W'(NUM_LANES)));

  assert_busy_from_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  assert_stop_on_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lane_fail_w |=> (!busy_o && done_o && err_o));

  assert_err_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> done_o);

  assert_cause_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (err_cause_o != 2'd0));

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lag
    assert_dq_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_code_o[g*CODE_W +: CODE_W] == '0) ||
      (dq_code_o[g*CODE_W +: CODE_W] ==
       dqs_code_o[g*CODE_W +: CODE_W] + CODE_W'(DQ_LAG)));
  end

endmodule

bind wlf_finalizer wlf_finalizer_chk #(
  .NUM_LANES (NUM_LANES),
  .CODE_W    (CODE_W),
  .DQ_LAG    (DQ_LAG)
) i_wlf_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .err_cause_o (err_cause_o),
  .lane_fail_w (lane_fail_w),
  .dqs_code_o  (dqs_code_o),
  .dq_code_o   (dq_code_o)
);

// File: tb/test_wlf_finalizer.sv
module test_wlf_finalizer;

  localparam int NL = 8;
  localparam int CW = 10;
  localparam int LW = $clog2(NL);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [NL*CW-1:0] region_start_i = '0;
  logic [NL*CW-1:0] region_width_i = '0;
  logic             x16_i = 1'b0;
  logic             qclk_fix_i = 1'b0;
  logic [NL*CW-1:0] dqs_code_o, dq_code_o;
  logic             busy_o, done_o, err_o;
  logic [LW-1:0]    err_lane_o;
  logic [1:0]       err_cause_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  int st_a[NL];
  int wd_a[NL];
  bit x16_a, fix_a;
  int exp_dqs[NL];
  int exp_dq[NL];
  int exp_err, exp_lane, exp_cause;

  always #4 clk = ~clk;

  wlf_finalizer i_wlf_finalizer (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .region_start_i (region_start_i),
    .region_width_i (region_width_i),
    .x16_i          (x16_i),
    .qclk_fix_i     (qclk_fix_i),
    .dqs_code_o     (dqs_code_o),
    .dq_code_o      (dq_code_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .err_o          (err_o),
    .err_lane_o     (err_lane_o),
    .err_cause_o    (err_cause_o)
  );

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference computation straight from the requirements.
  task automatic predict();
    exp_err = 0; exp_lane = 0; exp_cause = 0;
    for (int i = 0; i < NL; i++) begin
      exp_dqs[i] = 0;
      exp_dq[i]  = 0;
    end
    for (int i = 0; i < NL; i++) begin
      int s;
      if (wd_a[i] <= 32) begin exp_err = 1; exp_lane = i; exp_cause = 1; break; end
      if (wd_a[i] >= 96) begin exp_err = 1; exp_lane = i; exp_cause = 2; break; end
      s = st_a[i];
      if (x16_a && (i % 2 == 1)) begin
        if (s - st_a[i-1] > 64)       s = s - 128;
        else if (s - st_a[i-1] < -64) s = s + 128;
      end
      if (fix_a) s = s + 64;
      if (s < 0 || s + 32 > 1023) begin exp_err = 1; exp_lane = i; exp_cause = 3; break; end
      exp_dqs[i] = s;
      exp_dq[i]  = s + 32;
    end
  endtask

  task automatic drive_inputs(input bit scramble);
    for (int i = 0; i < NL; i++) begin
      region_start_i[i*CW +: CW] = scramble ? ~CW'(st_a[i]) : CW'(st_a[i]);
      region_width_i[i*CW +: CW] = scramble ? CW'(40 + 3 * i) : CW'(wd_a[i]);
    end
    x16_i      = scramble ? ~x16_a : x16_a;
    qclk_fix_i = scramble ? ~fix_a : fix_a;
  endtask

  task automatic run_case(input string req, input bit poke);
    int k, busy_seen, due;
    predict();
    @(negedge clk);
    drive_inputs(1'b0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    k = 1;
    busy_seen = 0;
    while (!done_o && k < NL + 6) begin
      if (busy_o) busy_seen++;
      if (poke && k == 2) begin
        drive_inputs(1'b1);   // R12: new data while busy
        start_i = 1'b1;       // R11: start while busy
      end
      if (poke && k == 3) start_i = 1'b0;
      @(negedge clk);
      k++;
    end
    start_i = 1'b0;
    due = exp_err ? exp_lane + 2 : NL + 1;
    check_eq("R2", "done sample index", k, due);
    check_eq("R2", "busy samples", busy_seen, due - 1);
    check_eq(req, "err_o", int'(err_o), exp_err);
    check_eq(req, "err_cause_o", int'(err_cause_o), exp_cause);
    if (exp_err) check_eq(req, "err_lane_o", int'(err_lane_o), exp_lane);
    for (int i = 0; i < NL; i++) begin
      check_eq(req, $sformatf("dqs lane %0d", i), int'(dqs_code_o[i*CW +: CW]), exp_dqs[i]);
      check_eq("R9", $sformatf("dq lane %0d", i), int'(dq_code_o[i*CW +: CW]), exp_dq[i]);
    end
    @(negedge clk);
    check_eq("R2", "done one cycle", int'(done_o), 0);
    check_eq("R2", "busy after done", int'(busy_o), 0);
  endtask

  task automatic fill(input int s0, input int step, input int w);
    for (int i = 0; i < NL; i++) begin
      st_a[i] = s0 + step * i;
      wd_a[i] = w;
    end
  endtask

  task automatic t_reset();  // R1
    check_eq("R1", "busy_o", int'(busy_o), 0);
    check_eq("R1", "done_o", int'(done_o), 0);
    check_eq("R1", "err_o", int'(err_o), 0);
    check_eq("R1", "err_cause_o", int'(err_cause_o), 0);
    check_eq("R1", "dqs bus zero", int'(dqs_code_o == '0), 1);
    check_eq("R1", "dq bus zero", int'(dq_code_o == '0), 1);
  endtask

  task automatic t_plain();  // R2, R9
    fill(180, 37, 60);
    x16_a = 0; fix_a = 0;
    run_case("R2", 1'b0);
  endtask

  task automatic t_fix();  // R8
    fill(150, 41, 70);
    x16_a = 0; fix_a = 1;
    run_case("R8", 1'b0);
  endtask

  task automatic t_fold();  // R6, R7
    st_a = '{200, 265, 300, 364, 400, 335, 500, 436};
    for (int i = 0; i < NL; i++) wd_a[i] = 64;
    x16_a = 1; fix_a = 0;
    run_case("R6", 1'b0);
  endtask

  task automatic t_nofold();  // R7 with x16 clear
    st_a = '{200, 265, 300, 364, 400, 335, 500, 436};
    for (int i = 0; i < NL; i++) wd_a[i] = 64;
    x16_a = 0; fix_a = 0;
    run_case("R7", 1'b0);
  endtask

  task automatic t_narrow();  // R3
    fill(220, 11, 60);
    wd_a[3] = 32;
    x16_a = 0; fix_a = 0;
    run_case("R3", 1'b0);
  endtask

  task automatic t_edges();  // R5
    fill(230, 9, 33);
    for (int i = 1; i < NL; i += 2) wd_a[i] = 95;
    x16_a = 0; fix_a = 0;
    run_case("R5", 1'b0);
  endtask

  task automatic t_wide();  // R4, also clearing from R2
    fill(300, 5, 60);
    wd_a[0] = 96;
    x16_a = 0; fix_a = 0;
    run_case("R4", 1'b0);
  endtask

  task automatic t_negative();  // R10 negative DQS
    fill(300, 3, 50);
    st_a[0] = 0; st_a[1] = 70;
    x16_a = 1; fix_a = 0;
    run_case("R10", 1'b0);
  endtask

  task automatic t_negative_fixed();  // R8 rescues the same case
    fill(300, 3, 50);
    st_a[0] = 0; st_a[1] = 70;
    x16_a = 1; fix_a = 1;
    run_case("R8", 1'b0);
  endtask

  task automatic t_high();  // R10 DQ above 1023, 991 still fits
    fill(400, 20, 50);
    st_a[4] = 991; st_a[5] = 992;
    x16_a = 0; fix_a = 0;
    run_case("R10", 1'b0);
  endtask

  task automatic t_busy_start();  // R11, R12
    fill(190, 23, 55);
    x16_a = 1; fix_a = 1;
    run_case("R11/R12", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_fix();
    t_fold();
    t_nofold();
    t_narrow();
    t_edges();
    t_plain();
    t_wide();
    t_negative();
    t_negative_fixed();
    t_high();
    t_busy_start();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL R2 watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule